// File: doc/BRIEF.md
# Safe Step Sequencer with Illegal-Code Recovery

This block is a control sequencer that walks through thirteen legal positions, one position per clock on which its advance input is high. Position 0 is the idle (home) position, and the last legal position wraps back to home. The position lives in a four-bit binary register, so three of the sixteen codes (13, 14 and 15) can never be reached through normal stepping. They can still appear if a disturbance such as a particle strike or electrical noise flips a register bit.

Dedicated, always-present logic compares the register against the legal range on every clock. Any out-of-range code is returned to home on the next clock, and a sticky error flag is raised that only reset clears. Because the check is an ordinary range comparison driving real registers, and not a default branch for an unreachable case, it stays in the netlist after optimisation.

The decoded stage outputs are defined for all sixteen codes, so a corrupted register drives them to their inactive value and never to an undefined one. A test input loads any four-bit value into the register, so that upsets can be injected on purpose.

Top module: `safeSequencer`

## Requirements
- R1: While synchronous reset is high at a clock edge, the register is loaded with 0 at that edge and the error flag is cleared. After that edge `stateCode` reads 0, `errorFlag` reads 0 and every bit of `stageHot` is 0.
- R2: In a legal code k from 0 to 11, an edge with `advance` high moves the register to k+1. An edge with `advance` low leaves it at k.
- R3: In code 12, the last legal code, an edge with `advance` high moves the register to code 0.
- R4: Codes 13, 14 and 15 are illegal. From an illegal code, the next clock edge loads code 0 whatever the value of `advance`, so recovery takes exactly one clock.
- R5: `errorFlag` becomes 1 at the edge that ends a cycle in which the register holds an illegal code. It then stays 1 through any stepping and any later injection.
- R6: For a legal code k from 1 to 12, `stageHot` has only bit k-1 set. For code 0 and for codes 13 to 15, `stageHot` is all zeros.
- R7: An edge with `injectEn` high loads `injectCode` into the register. Injection takes priority over `advance` and over recovery.
- R8: Only reset clears `errorFlag`. Injecting a legal code after an error leaves the flag at 1.
- R9: Legal stepping alone never sets `errorFlag`, including across a full wrap of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Step request for the sequencer |
| injectEn | input | 1 | Test hook: load `injectCode` into the state register |
| injectCode | input | 4 | Value forced into the state register when `injectEn` is high |
| stageHot | output | 12 | Decoded stage strobes; bit k-1 is high in legal code k |
| stateCode | output | 4 | Current state register value |
| errorFlag | output | 1 | Sticky illegal-code flag, cleared by reset only |

## Verification
The hardest condition to reach from the ports is the register sitting on one of the three illegal codes, because normal stepping can never produce them. The bench uses the injection hook to place each of 13, 14 and 15 in the register, one at a time. It then checks the same things for each code:
- the quiet outputs during the one corrupted cycle;
- the one-clock return to home while `advance` is held high, which tries to push the register forward;
- the flag staying set through further stepping and through a legal injection, until a reset clears it.

// File: rtl/seqPkg.sv
package seqPkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic loadInject;  // take the test value
    logic goHome;      // recover from an illegal code
    logic stepUp;      // move to the next legal code
    logic wrapUp;      // leave the last legal code for home
    logic flagSet;     // an illegal code is present this cycle
  } seqStrobeT;

endpackage

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
#(
  parameter int STATE_W    = 4,
  parameter int NUM_STATES = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advance,
  input  logic               injectEn,
  input  logic [STATE_W-1:0] stateQ,
  output seqStrobeT          strobes
);

  localparam logic [STATE_W-1:0] LAST_CODE = STATE_W'(NUM_STATES - 1);

  logic isIllegal;
  logic isLast;
  logic moveOk;

  // Range check kept as real logic: it drives both recovery and the flag.
  assign isIllegal = (int'(stateQ) >= NUM_STATES);
  assign isLast    = (stateQ == LAST_CODE);
  assign moveOk    = advance && !isIllegal && !injectEn;

  always_comb begin
    strobes.loadInject = injectEn;
    strobes.goHome     = isIllegal && !injectEn;
    strobes.stepUp     = moveOk && !isLast;
    strobes.wrapUp     = moveOk && isLast;
    strobes.flagSet    = isIllegal;
  end

  AST_STEP_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (advance && !injectEn && (int'(stateQ) < NUM_STATES - 1)) |=> (stateQ == $past(stateQ) + STATE_W'(1))); // R2

  AST_HOLD_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!advance && !injectEn && (int'(stateQ) < NUM_STATES)) |=> $stable(stateQ)); // R2

  AST_WRAP_TO_HOME: assert property (@(posedge clk) disable iff (rst)
    (advance && !injectEn && stateQ == LAST_CODE) |=> (stateQ == '0)); // R3

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int STATE_W    = 4,
  parameter int NUM_STATES = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  seqStrobeT             strobes,
  input  logic [STATE_W-1:0]    injectCode,
  output logic [STATE_W-1:0]    stateQ,
  output logic                  errorQ,
  output logic [NUM_STATES-2:0] stageHot
);

  localparam int HOT_W = NUM_STATES - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= '0;
      errorQ <= 1'b0;
    end else begin
      if (strobes.loadInject) begin
        stateQ <= injectCode;
      end else if (strobes.goHome || strobes.wrapUp) begin
        stateQ <= '0;
      end else if (strobes.stepUp) begin
        stateQ <= stateQ + STATE_W'(1);
      end
      if (strobes.flagSet) begin
        errorQ <= 1'b1;
      end
    end
  end

  // Each strobe compares against its own code. Home and every out-of-range
  // code match no strobe, so all sixteen codes give a defined output.
  for (genvar i = 0; i < HOT_W; i++) begin : gHot
    assign stageHot[i] = (stateQ == STATE_W'(i + 1));
  end

  AST_RECOVER_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    ((int'(stateQ) >= NUM_STATES) && !strobes.loadInject) |=> (stateQ == '0)); // R4

  AST_FLAG_ON_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (int'(stateQ) >= NUM_STATES) |=> errorQ); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    errorQ |=> errorQ); // R8

  AST_INJECT_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobes.loadInject |=> (stateQ == $past(injectCode))); // R7

  AST_OUT_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stageHot)); // R6

  AST_OUT_QUIET_BAD: assert property (@(posedge clk) disable iff (rst)
    ((int'(stateQ) >= NUM_STATES) || stateQ == '0) |-> (stageHot == '0)); // R6

endmodule

// File: rtl/safeSequencer.sv
module safeSequencer
  import seqPkg::*;
#(
  parameter int STATE_W    = 4,
  parameter int NUM_STATES = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  advance,
  input  logic                  injectEn,
  input  logic [STATE_W-1:0]    injectCode,
  output logic [NUM_STATES-2:0] stageHot,
  output logic [STATE_W-1:0]    stateCode,
  output logic                  errorFlag
);

  seqStrobeT          strobes;
  logic [STATE_W-1:0] stateQ;

  seqControl #(.STATE_W(STATE_W), .NUM_STATES(NUM_STATES)) uControl (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .injectEn (injectEn),
    .stateQ   (stateQ),
    .strobes  (strobes)
  );

  seqDatapath #(.STATE_W(STATE_W), .NUM_STATES(NUM_STATES)) uDatapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .injectCode (injectCode),
    .stateQ     (stateQ),
    .errorQ     (errorFlag),
    .stageHot   (stageHot)
  );

  assign stateCode = stateQ;

endmodule

// File: tb/tb_safeSequencer.sv
`timescale 1ns/1ps
module tb_safeSequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic        injectEn = 1'b0;
  logic [3:0]  injectCode = 4'd0;
  logic [11:0] stageHot;
  logic [3:0]  stateCode;
  logic        errorFlag;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  safeSequencer dut (
    .clk(clk), .rst(rst), .advance(advance), .injectEn(injectEn),
    .injectCode(injectCode), .stageHot(stageHot), .stateCode(stateCode),
    .errorFlag(errorFlag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock edge; inputs change and outputs are sampled 1 ns after the edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int hotFor(input int code);
    return (code >= 1 && code <= 12) ? (1 << (code - 1)) : 0;
  endfunction

  task automatic doReset();
    rst = 1'b1; advance = 1'b0; injectEn = 1'b0;
    tick();
    rst = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    check("R1", "state after reset", int'(stateCode), 0);
    check("R1", "flag after reset", int'(errorFlag), 0);
    check("R1", "stages after reset", int'(stageHot), 0);
  endtask

  task automatic tSweep();
    doReset();
    advance = 1'b0;
    tick();
    check("R2", "hold at home", int'(stateCode), 0);
    for (int k = 1; k <= 12; k++) begin
      advance = 1'b1;
      tick();
      check("R2", "step", int'(stateCode), k);
      check("R6", "stage decode", int'(stageHot), hotFor(k));
      if (k == 6) begin
        advance = 1'b0;
        tick();
        check("R2", "hold mid", int'(stateCode), 6);
      end
    end
    advance = 1'b1;
    tick();
    check("R3", "wrap to home", int'(stateCode), 0);
    check("R6", "stages at home", int'(stageHot), 0);
    check("R9", "no flag after wrap", int'(errorFlag), 0);
    for (int k = 0; k < 13; k++) tick();
    check("R9", "no flag after second lap", int'(errorFlag), 0);
    check("R3", "second lap back home", int'(stateCode), 0);
    advance = 1'b0;
  endtask

  task automatic tIllegal(input int code);
    doReset();
    advance = 1'b1;
    injectEn = 1'b1; injectCode = 4'(code);
    tick();
    injectEn = 1'b0;
    check("R7", "illegal code loaded", int'(stateCode), code);
    check("R6", "stages quiet on illegal", int'(stageHot), 0);
    check("R5", "flag not yet set", int'(errorFlag), 0);
    tick();
    check("R4", "recovered home in one clock", int'(stateCode), 0);
    check("R5", "flag set", int'(errorFlag), 1);
    tick(); tick();
    check("R5", "stepping after recovery", int'(stateCode), 2);
    check("R5", "flag still set", int'(errorFlag), 1);
    injectEn = 1'b1; injectCode = 4'd5;
    tick();
    injectEn = 1'b0; advance = 1'b0;
    check("R7", "legal inject", int'(stateCode), 5);
    tick();
    check("R8", "legal inject keeps flag", int'(errorFlag), 1);
    doReset();
    check("R8", "reset clears flag", int'(errorFlag), 0);
  endtask

  task automatic tOverride();
    doReset();
    advance = 1'b1;
    tick(); tick(); tick();
    check("R2", "reached 3", int'(stateCode), 3);
    injectEn = 1'b1; injectCode = 4'd9;
    tick();
    injectEn = 1'b0; advance = 1'b0;
    check("R7", "inject beats advance", int'(stateCode), 9);
    check("R6", "decode after inject", int'(stageHot), hotFor(9));
  endtask

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1;
    tReset();
    tSweep();
    for (int c = 13; c <= 15; c++) tIllegal(c);
    tOverride();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule